// File: doc/BRIEF.md
# Tri-state OOK frame decoder

The block sits behind an already de-glitched on-off-keyed receiver output. It turns a stream of high and low runs into a frame of twelve tri-state symbols. A pulse on `tick_i` marks one time unit, nominally 100 us. The line is sampled only on those pulses.

Every symbol lasts 32 units and is built from a high run, a low run, a second high run and a second low run. The lengths of the two high runs give the symbol's value:

- both short: zero
- both long: one
- short then long: floating

A short high run followed by a very long low run is the sync symbol that closes the frame.

When exactly twelve data symbols have been followed by sync, the decoded codes are copied to `sym_o` and `frame_valid_o` pulses for one cycle. Any malformed run pulses `err_o` and drops the partial frame. The decoder then waits for the next rising edge, which starts a new frame. `sym_o` keeps the last good frame until a new one completes.

Top module: `tsd_frame_decoder`

## Requirements
- R1: `data_i` is sampled only in cycles where `tick_i` is high. Any change that reverts before the next tick has no effect on the decoded frame.
- R2: Symbol codes are zero = 2'b00, one = 2'b01 and floating = 2'b10. The first symbol received sits in `sym_o[1:0]`, and symbol k sits in `sym_o[2k+1:2k]`.
- R3: A high run of 2 to 7 units is short. A high run of 8 to 16 units is long. Low runs inside a symbol are accepted for 2 to 16 units.
- R4: A high run of 1 unit, or one that reaches 17 units, pulses `err_o` for one cycle. The partial frame is abandoned.
- R5: Sync is a short high run followed by a low run that reaches 17 units. `frame_valid_o` is high for exactly one cycle, the cycle after the tick that samples the 17th low unit.
- R6: `frame_valid_o` is raised only if exactly 12 data symbols preceded sync. Sync after fewer symbols, or a 13th data symbol, pulses `err_o` instead.
- R7: `sym_o` changes only together with `frame_valid_o`. It is left unchanged by errors.
- R8: A long first high run followed by a short second high run pulses `err_o`.
- R9: A low run of 1 unit pulses `err_o`. So does a long first high run followed by 17 low units, or a second low run that reaches 17 units.
- R10: After reset, `sym_o` is all zero and `frame_valid_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per time unit |
| data_i | input | 1 | Cleaned keyed line, high = carrier on |
| sym_o | output | 2*N_SYM | Codes of the last good frame, symbol 0 in the low bits |
| frame_valid_o | output | 1 | One-cycle pulse when a good frame has been latched |
| err_o | output | 1 | One-cycle pulse on a malformed run or frame |

## Verification
The hardest cases are the run lengths at the edges of the classes. One is a high run of exactly 16 units followed by a 16-unit low run in the second half of a symbol. The other is the split between a sync low run and an over-long data space, which only differ by which high run came before. The stimulus builds whole frames from explicit run lengths at each boundary. It places each defect after several good symbols, so the error is caught mid-frame rather than at the start. Each error case checks that `sym_o` still shows the previous good frame. Sync timing is checked at the 16th and 17th low unit.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef enum logic [1:0] {LEN_SHORT = 2'd0, LEN_LONG = 2'd1, LEN_BAD = 2'd2} len_cls_e;
  typedef enum logic [1:0] {SYM_ZERO = 2'b00, SYM_ONE = 2'b01, SYM_FLOAT = 2'b10} sym_code_e;
  typedef enum logic [2:0] {ST_IDLE, ST_MARK0, ST_SPACE0, ST_MARK1, ST_SPACE1} dec_state_e;
endpackage

// File: rtl/tsd_run_meter.sv
module tsd_run_meter #(
  parameter int unsigned LEN_MAX = 16,
  parameter int unsigned LEN_W   = $clog2(LEN_MAX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             data_i,
  output logic             run_end_o,
  output logic             run_lvl_o,
  output logic [LEN_W-1:0] run_len_o,
  output logic             over_o
);
  localparam logic [LEN_W-1:0] LenSat = LEN_W'(LEN_MAX + 1);

  logic             lvl_q;
  logic [LEN_W-1:0] len_q;

  assign run_end_o = tick_i && (data_i != lvl_q);
  assign over_o    = tick_i && (data_i == lvl_q) && (len_q == LEN_W'(LEN_MAX));
  assign run_lvl_o = lvl_q;
  assign run_len_o = len_q;

  // saturate so an endless run reports overflow once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      len_q <= LenSat;
    end else if (tick_i) begin
      if (data_i != lvl_q) begin
        lvl_q <= data_i;
        len_q <= LEN_W'(1);
      end else if (len_q != LenSat) begin
        len_q <= len_q + LEN_W'(1);
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(len_q) && $stable(lvl_q))); // R1
  AST_OVER_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |=> !over_o); // R4
endmodule

// File: rtl/tsd_len_class.sv
module tsd_len_class
  import tsd_pkg::*;
#(
  parameter int unsigned MIN_SHORT = 2,
  parameter int unsigned MIN_LONG  = 8,
  parameter int unsigned MAX_LONG  = 16,
  parameter int unsigned LEN_W     = $clog2(MAX_LONG + 2)
) (
  input  logic [LEN_W-1:0] len_i,
  output len_cls_e         cls_o
);
  always_comb begin
    if (len_i < LEN_W'(MIN_SHORT) || len_i > LEN_W'(MAX_LONG)) cls_o = LEN_BAD;
    else if (len_i < LEN_W'(MIN_LONG))                          cls_o = LEN_SHORT;
    else                                                        cls_o = LEN_LONG;
  end
endmodule

// File: rtl/tsd_sym_decode.sv
module tsd_sym_decode
  import tsd_pkg::*;
(
  input  len_cls_e  first_i,
  input  len_cls_e  second_i,
  output sym_code_e code_o,
  output logic      valid_o
);
  always_comb begin
    code_o  = SYM_ZERO;
    valid_o = 1'b1;
    unique case ({first_i, second_i})
      {LEN_SHORT, LEN_SHORT}: code_o = SYM_ZERO;
      {LEN_LONG,  LEN_LONG }: code_o = SYM_ONE;
      {LEN_SHORT, LEN_LONG }: code_o = SYM_FLOAT;
      default:                valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsd_frame_decoder.sv
module tsd_frame_decoder
  import tsd_pkg::*;
#(
  parameter int unsigned N_SYM     = 12,
  parameter int unsigned MIN_SHORT = 2,
  parameter int unsigned MIN_LONG  = 8,
  parameter int unsigned MAX_LONG  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               data_i,
  output logic [2*N_SYM-1:0] sym_o,
  output logic               frame_valid_o,
  output logic               err_o
);
  localparam int unsigned LEN_W = $clog2(MAX_LONG + 2);
  localparam int unsigned CNT_W = $clog2(N_SYM + 1);

  logic             run_end, run_lvl, over;
  logic [LEN_W-1:0] run_len;
  len_cls_e         run_cls;
  sym_code_e        dec_code;
  logic             dec_ok;

  dec_state_e         state_q, state_d;
  logic [CNT_W-1:0]   nsym_q, nsym_d;
  len_cls_e           first_q, first_d, second_q, second_d;
  logic [2*N_SYM-1:0] work_q, work_d, sym_q, sym_d;
  logic               valid_q, valid_d, err_q, err_d;

  tsd_run_meter #(.LEN_MAX(MAX_LONG), .LEN_W(LEN_W)) u_meter (
    .clk_i, .rst_ni, .tick_i, .data_i,
    .run_end_o(run_end), .run_lvl_o(run_lvl), .run_len_o(run_len), .over_o(over)
  );

  tsd_len_class #(.MIN_SHORT(MIN_SHORT), .MIN_LONG(MIN_LONG), .MAX_LONG(MAX_LONG),
                  .LEN_W(LEN_W)) u_class (.len_i(run_len), .cls_o(run_cls));

  tsd_sym_decode u_sym (.first_i(first_q), .second_i(second_q),
                        .code_o(dec_code), .valid_o(dec_ok));

  always_comb begin
    state_d  = state_q;
    nsym_d   = nsym_q;
    first_d  = first_q;
    second_d = second_q;
    work_d   = work_q;
    sym_d    = sym_q;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (run_end && !run_lvl) begin
        state_d = ST_MARK0;
        nsym_d  = '0;
      end
      ST_MARK0, ST_MARK1: begin
        if (over) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (run_end) begin
          if (run_cls == LEN_BAD) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (state_q == ST_MARK0) begin
            first_d = run_cls;
            state_d = ST_SPACE0;
          end else begin
            second_d = run_cls;
            state_d  = ST_SPACE1;
          end
        end
      end
      ST_SPACE0: begin
        if (over) begin
          // long space after a short mark closes the frame
          if (first_q == LEN_SHORT && nsym_q == CNT_W'(N_SYM)) begin
            valid_d = 1'b1;
            sym_d   = work_q;
          end else begin
            err_d = 1'b1;
          end
          state_d = ST_IDLE;
        end else if (run_end) begin
          if (run_cls == LEN_BAD) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_MARK1;
          end
        end
      end
      ST_SPACE1: begin
        if (over) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (run_end) begin
          if (run_cls == LEN_BAD || !dec_ok || nsym_q == CNT_W'(N_SYM)) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            for (int k = 0; k < N_SYM; k++) begin
              if (nsym_q == CNT_W'(k)) work_d[2*k +: 2] = dec_code;
            end
            nsym_d  = nsym_q + CNT_W'(1);
            state_d = ST_MARK0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nsym_q   <= '0;
      first_q  <= LEN_SHORT;
      second_q <= LEN_SHORT;
      work_q   <= '0;
      sym_q    <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      nsym_q   <= nsym_d;
      first_q  <= first_d;
      second_q <= second_d;
      work_q   <= work_d;
      sym_q    <= sym_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
    end
  end

  assign sym_o         = sym_q;
  assign frame_valid_o = valid_q;
  assign err_o         = err_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o); // R5
  AST_VALID_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> $past(state_q) == ST_SPACE0); // R5
  AST_VALID_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && err_o)); // R6
  AST_NSYM_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nsym_q <= CNT_W'(N_SYM)); // R6
  AST_SYM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> $stable(sym_o)); // R7
endmodule

// File: tb/tsd_frame_decoder_tb.sv
module tsd_frame_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        data_i = 1'b0;
  logic [23:0] sym_o;
  logic        frame_valid_o, err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {bit is_valid; logic [23:0] sym; string req;} exp_t;
  exp_t        q[$];
  logic [23:0] last_sym = '0;

  always #5 clk_i = ~clk_i;

  tsd_frame_decoder u_dut (.clk_i, .rst_ni, .tick_i, .data_i, .sym_o, .frame_valid_o, .err_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit v, input logic [23:0] s, input string req);
    exp_t e;
    e.is_valid = v; e.sym = s; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && (frame_valid_o || err_o)) begin
      if (q.size() == 0) begin
        chk("R6 unexpected event", {30'd0, frame_valid_o, err_o}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, {30'd0, frame_valid_o, err_o}, e.is_valid ? 32'd2 : 32'd1);
        chk({e.req, " R7 sym"}, {8'd0, sym_o}, {8'd0, e.sym});
      end
    end
  end

  task automatic unit(input logic v, input bit g);
    data_i = v;
    @(negedge clk_i);
    if (g) data_i = ~v;
    @(negedge clk_i);
    data_i = v;
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic run(input logic v, input int n, input bit g);
    repeat (n) unit(v, g);
  endtask

  task automatic sym_w(input int m0, input int s0, input int m1, input int s1, input bit g);
    run(1'b1, m0, g); run(1'b0, s0, g); run(1'b1, m1, g); run(1'b0, s1, g);
  endtask

  task automatic sym_c(input int c, input bit g);
    case (c)
      0:       sym_w(4, 12, 4, 12, g);
      1:       sym_w(12, 4, 12, 4, g);
      default: sym_w(4, 12, 12, 4, g);
    endcase
  endtask

  task automatic sync_tail(input bit chk_time);
    run(1'b1, 4, 1'b0);
    for (int i = 1; i <= 28; i++) begin
      unit(1'b0, 1'b0);
      if (chk_time && i == 16) chk("R5 before 17th", {31'd0, frame_valid_o}, 32'd0);
      if (chk_time && i == 17) chk("R5 at 17th", {31'd0, frame_valid_o}, 32'd1);
    end
  endtask

  function automatic logic [23:0] pack(input int f[12]);
    logic [23:0] r = '0;
    for (int k = 0; k < 12; k++) r[2*k +: 2] = 2'(f[k]);
    return r;
  endfunction

  task automatic good_frame(input int f[12], input bit g, input string req);
    last_sym = pack(f);
    push(1'b1, last_sym, req);
    for (int k = 0; k < 12; k++) sym_c(f[k], g);
    sync_tail(1'b1);
    run(1'b0, 8, 1'b0);
  endtask

  initial begin
    int fa[12] = '{0, 1, 2, 0, 1, 2, 2, 1, 0, 0, 1, 2};
    int fb[12] = '{0, 1, 2, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    int fc[12] = '{2, 1, 0, 0, 2, 1, 1, 2, 0, 2, 1, 0};
    int fd[12] = '{2, 2, 2, 2, 1, 1, 1, 1, 0, 0, 0, 0};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 sym", {8'd0, sym_o}, 32'd0);
    chk("R10 valid", {31'd0, frame_valid_o}, 32'd0);
    chk("R10 err", {31'd0, err_o}, 32'd0);
    run(1'b0, 5, 1'b0);

    good_frame(fa, 1'b0, "R2 nominal frame");

    // R3 class boundaries: 2/7 short, 8/16 long, spaces 2 and 16
    last_sym = pack(fb);
    push(1'b1, last_sym, "R3 boundary frame");
    sym_w(2, 16, 7, 2, 1'b0);
    sym_w(8, 2, 16, 16, 1'b0);
    sym_w(7, 9, 8, 8, 1'b0);
    for (int k = 3; k < 12; k++) sym_c(fb[k], 1'b0);
    sync_tail(1'b1);
    run(1'b0, 8, 1'b0);

    good_frame(fc, 1'b1, "R1 glitches between ticks");

    push(1'b0, last_sym, "R4 mark of 1 unit");
    sym_c(1, 0); sym_c(0, 0); sym_c(2, 0);
    run(1'b1, 1, 1'b0); run(1'b0, 40, 1'b0);

    push(1'b0, last_sym, "R4 mark of 17+ units");
    sym_c(0, 0); sym_c(1, 0);
    run(1'b1, 20, 1'b0); run(1'b0, 40, 1'b0);

    push(1'b0, last_sym, "R6 eleven symbols");
    for (int k = 0; k < 11; k++) sym_c(fa[k], 1'b0);
    sync_tail(1'b0);

    push(1'b0, last_sym, "R6 thirteen symbols");
    for (int k = 0; k < 13; k++) sym_c(k % 3, 1'b0);
    sync_tail(1'b0);

    push(1'b0, last_sym, "R8 long then short mark");
    sym_c(0, 0); sym_c(2, 0);
    sym_w(12, 4, 4, 12, 1'b0);
    sync_tail(1'b0);

    push(1'b0, last_sym, "R9 space of 1 unit");
    sym_c(1, 0);
    run(1'b1, 4, 1'b0); run(1'b0, 1, 1'b0); run(1'b1, 4, 1'b0); run(1'b0, 40, 1'b0);

    push(1'b0, last_sym, "R9 long mark then long space");
    run(1'b1, 12, 1'b0); run(1'b0, 40, 1'b0);

    push(1'b0, last_sym, "R9 second space too long");
    sym_c(0, 0);
    run(1'b1, 4, 1'b0); run(1'b0, 12, 1'b0); run(1'b1, 4, 1'b0); run(1'b0, 40, 1'b0);

    good_frame(fd, 1'b0, "R2 recovery frame");

    run(1'b0, 10, 1'b0);
    chk("R6 all expected events seen", q.size(), 32'd0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule